// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU's 16-bit bus and the ROM and save RAM of a plug-in cartridge. CPU writes into the read-only window 0x0000-0x7FFF never reach storage. The block takes the address and data of each such write as a command. Depending on which slice of that window is hit, the command sets a save-RAM access flag, part of the switchable ROM bank number, the RAM bank number, or a steering mode. For every CPU access the block turns the 16-bit bus address into a wide physical ROM address and a physical RAM address. It also raises a RAM access qualifier when save RAM may be touched.

A parameter selects one of three command sets. The first has a 5-bit low ROM field plus a 2-bit field that a mode bit steers to either ROM bank bits 6:5 or the RAM bank. The second has a flat 7-bit ROM bank and a 2-bit RAM bank. The third has a 9-bit ROM bank split into a low byte and a top bit, with a 4-bit RAM bank. The numbers of ROM and RAM banks are parameters and must be powers of two, at most 512 and 16. The block holds no storage, clock or motor logic of its own.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, before any command, the ROM bank is 1 (masked by the ROM bank count), the RAM bank is 0 and RAM access is off.
- R2: A strobed write anywhere in 0x0000-0x1FFF turns RAM access on when data bits 3:0 equal 0xA and off for any other value. ram_access is high only while RAM access is on and the address lies in 0xA000-0xBFFF.
- R3: For addresses 0x0000-0x3FFF, rom_addr is {zero bank, addr[13:0]}. For 0x4000-0x7FFF it is {current ROM bank, addr[13:0]}.
- R4: ram_addr is {current RAM bank, addr[12:0]}.
- R5: Command set 0 (FLAVOR=0): a write to 0x2000-0x3FFF loads ROM bank bits 4:0 from data bits 4:0, with 0 replaced by 1. ROM bank bits 6:5 are kept and data bits 7:5 are ignored.
- R6: Command set 0: a write to 0x4000-0x5FFF takes data bits 1:0. With the mode bit clear they become ROM bank bits 6:5. With it set they become the RAM bank and the ROM bank is unchanged.
- R7: Command set 0: a write to 0x6000-0x7FFF sets the mode bit from data bit 0.
- R8: Command set 1 (FLAVOR=1): a write to 0x2000-0x3FFF loads the ROM bank from data bits 6:0, with 0 replaced by 1. A write to 0x4000-0x5FFF loads the RAM bank from data bits 1:0. Writes to 0x6000-0x7FFF have no effect.
- R9: Command set 2 (FLAVOR=2): a write to 0x2000-0x2FFF loads ROM bank bits 7:0 from the data byte, with 0x00 replaced by 1. A write to 0x3000-0x3FFF loads ROM bank bit 8 from data bit 0. A write to 0x4000-0x5FFF loads the RAM bank from data bits 3:0. Writes to 0x6000-0x7FFF have no effect.
- R10: After each command write the ROM bank is ANDed with (ROM_BANKS-1) and the RAM bank with (RAM_BANKS-1). This applies after the zero-to-one substitution, so a result of 0 is possible.
- R11: Bank numbers and RAM access keep their values in any cycle without a write strobe, and on strobed writes to 0x8000-0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands take effect on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe for the current address and data |
| rom_addr | output | ROM_AW (23 by default) | Physical ROM address: bank number above addr[13:0] |
| ram_addr | output | RAM_AW (17 by default) | Physical save-RAM address: RAM bank above addr[12:0] |
| ram_access | output | 1 | High when RAM access is on and the address is in 0xA000-0xBFFF |

## Verification
The bench writes a zero bank value in each command set. A design that skipped the zero-to-one substitution would show bank 0 in the switchable window. It also writes 0x40 into a 64-bank set, so that masking after the substitution gives bank 0; a design that masked first would give bank 1 or 64. In command set 0 the two-bit field is written once with the mode bit clear and once with it set. Misrouting would move the ROM bank when it should stay, or leave the RAM bank stale. Other tests write the split high bit of the 9-bit bank in both directions, use enable values whose high nibble differs from the enable code, and strobe writes above 0x7FFF or present writes without the strobe. A design with a loose region decode or a missing strobe qualifier would change a bank number in those tests.

// File: rtl/cbc_pkg.sv
// Shared definitions for the cartridge bank controller.
// Assumes: command sets are chosen by an integer parameter, 0..2.
package cbc_pkg;

    localparam int unsigned FLV_5P2 = 0;  // 5-bit low field + 2-bit steered field
    localparam int unsigned FLV_7   = 1;  // flat 7-bit ROM bank
    localparam int unsigned FLV_9   = 2;  // 9-bit ROM bank split in two writes

    // Which piece of state a command write targets
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_EN,
        TGT_ROMLO,
        TGT_ROMHI,
        TGT_RAM,
        TGT_MODE
    } tgt_e;

endpackage

// File: rtl/cbc_cmd_decode.sv
// Command decoder: maps a strobed write address in 0x0000-0x7FFF to a
// state target according to the selected command set.
// Assumes: addr_hi is address bits 15:12; writes at 0x8000+ decode to none.
module cbc_cmd_decode
    import cbc_pkg::*;
#(
    parameter int unsigned FLAVOR = FLV_9
) (
    input  logic       wr,
    input  logic [3:0] addr_hi,
    output tgt_e       tgt
);

    generate
        if (FLAVOR == FLV_9) begin : g_split
            // Purpose: 4 KiB granularity decode for the split 9-bit set
            always_comb begin
                tgt = TGT_NONE;
                if (wr) begin
                    case (addr_hi)
                        4'h0, 4'h1: tgt = TGT_EN;
                        4'h2:       tgt = TGT_ROMLO;
                        4'h3:       tgt = TGT_ROMHI;
                        4'h4, 4'h5: tgt = TGT_RAM;
                        default:    tgt = TGT_NONE;
                    endcase
                end
            end
        end else begin : g_coarse
            // Purpose: 8 KiB granularity decode for the other two sets
            always_comb begin
                tgt = TGT_NONE;
                if (wr) begin
                    case (addr_hi[3:1])
                        3'd0:    tgt = TGT_EN;
                        3'd1:    tgt = TGT_ROMLO;
                        3'd2:    tgt = TGT_RAM;
                        3'd3:    tgt = (FLAVOR == FLV_5P2) ? TGT_MODE : TGT_NONE;
                        default: tgt = TGT_NONE;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cbc_bank_regs.sv
// Bank state: ROM bank, RAM bank, RAM access flag and (set 0 only) the
// steering mode bit. Computes the raw next value per command set, then
// masks by the bank counts.
// Assumes: ROM_BANKS <= 512 and RAM_BANKS <= 16, both powers of two.
module cbc_bank_regs
    import cbc_pkg::*;
#(
    parameter int unsigned FLAVOR    = FLV_9,
    parameter int unsigned ROM_BANKS = 512,
    parameter int unsigned RAM_BANKS = 16,
    parameter int unsigned ROM_BW    = 9,
    parameter int unsigned RAM_BW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              tgt,
    input  logic [7:0]        wdata,
    output logic [ROM_BW-1:0] rom_bank,
    output logic [RAM_BW-1:0] ram_bank,
    output logic              ram_on
);

    localparam logic [8:0]        ROM_MASK = 9'(ROM_BANKS - 1);
    localparam logic [3:0]        RAM_MASK = 4'(RAM_BANKS - 1);
    localparam logic [ROM_BW-1:0] ROM_RST  = ROM_BW'(9'd1 & ROM_MASK);

    logic [8:0] cur_rom, rom_raw;
    logic [3:0] cur_ram, ram_raw;

    assign cur_rom = 9'(rom_bank);
    assign cur_ram = 4'(ram_bank);

    generate
        if (FLAVOR == FLV_5P2) begin : g_f52
            logic       mode_q;
            logic [4:0] lo5;

            // Purpose: steering mode bit, loaded from data bit 0
            always_ff @(posedge clk) begin
                if (!rst_n)               mode_q <= 1'b0;
                else if (tgt == TGT_MODE) mode_q <= wdata[0];
            end

            assign lo5 = (wdata[4:0] == 5'd0) ? 5'd1 : wdata[4:0];

            // Purpose: raw next banks for the 5+2 command set
            always_comb begin
                rom_raw = cur_rom;
                ram_raw = cur_ram;
                case (tgt)
                    TGT_ROMLO: rom_raw = {2'b00, cur_rom[6:5], lo5};
                    TGT_RAM: begin
                        if (mode_q) ram_raw = {2'b00, wdata[1:0]};
                        else        rom_raw = {2'b00, wdata[1:0], cur_rom[4:0]};
                    end
                    default: ;
                endcase
            end
        end else if (FLAVOR == FLV_7) begin : g_f7
            logic [6:0] lo7;
            assign lo7 = (wdata[6:0] == 7'd0) ? 7'd1 : wdata[6:0];

            // Purpose: raw next banks for the flat 7-bit command set
            always_comb begin
                rom_raw = cur_rom;
                ram_raw = cur_ram;
                case (tgt)
                    TGT_ROMLO: rom_raw = {2'b00, lo7};
                    TGT_RAM:   ram_raw = {2'b00, wdata[1:0]};
                    default: ;
                endcase
            end
        end else begin : g_f9
            logic [7:0] lo8;
            assign lo8 = (wdata == 8'd0) ? 8'd1 : wdata;

            // Purpose: raw next banks for the split 9-bit command set
            always_comb begin
                rom_raw = cur_rom;
                ram_raw = cur_ram;
                case (tgt)
                    TGT_ROMLO: rom_raw = {cur_rom[8], lo8};
                    TGT_ROMHI: rom_raw = {wdata[0], cur_rom[7:0]};
                    TGT_RAM:   ram_raw = wdata[3:0];
                    default: ;
                endcase
            end
        end
    endgenerate

    // Purpose: register masked banks and the RAM access flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_bank <= ROM_RST;
            ram_bank <= '0;
            ram_on   <= 1'b0;
        end else begin
            rom_bank <= ROM_BW'(rom_raw & ROM_MASK);
            ram_bank <= RAM_BW'(ram_raw & RAM_MASK);
            if (tgt == TGT_EN) ram_on <= (wdata[3:0] == 4'hA);
        end
    end

endmodule

// File: rtl/cbc_addr_map.sv
// Address mapper: forms physical ROM and RAM addresses from the bus
// address and the current banks; qualifies save-RAM access.
// Assumes: purely combinational; rom_addr is meaningful below 0x8000.
module cbc_addr_map #(
    parameter int unsigned ROM_BW = 9,
    parameter int unsigned RAM_BW = 4
) (
    input  logic [15:0]          addr,
    input  logic [ROM_BW-1:0]    rom_bank,
    input  logic [RAM_BW-1:0]    ram_bank,
    input  logic                 ram_on,
    output logic [ROM_BW+13:0]   rom_addr,
    output logic [RAM_BW+12:0]   ram_addr,
    output logic                 ram_access
);

    logic [ROM_BW-1:0] win_bank;

    // Purpose: fixed window uses bank 0, switchable window the current bank
    assign win_bank   = addr[14] ? rom_bank : {ROM_BW{1'b0}};
    assign rom_addr   = {win_bank, addr[13:0]};
    assign ram_addr   = {ram_bank, addr[12:0]};
    assign ram_access = ram_on && (addr[15:13] == 3'b101);

endmodule

// File: rtl/cart_bank_ctrl.sv
// Cartridge bank controller top: decodes CPU writes to the ROM window
// as bank commands and maps CPU addresses to physical ROM/RAM addresses.
// Assumes: bank counts are powers of two (ROM <= 512, RAM <= 16);
// synchronous active-low reset; commands apply on the strobed edge.
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter  int unsigned FLAVOR    = FLV_9,
    parameter  int unsigned ROM_BANKS = 512,
    parameter  int unsigned RAM_BANKS = 16,
    localparam int unsigned ROM_BW    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
    localparam int unsigned RAM_BW    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int unsigned ROM_AW    = ROM_BW + 14,
    localparam int unsigned RAM_AW    = RAM_BW + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_access
);

    tgt_e              tgt;
    logic [ROM_BW-1:0] rom_bank;
    logic [RAM_BW-1:0] ram_bank;
    logic              ram_on;

    cbc_cmd_decode #(.FLAVOR(FLAVOR)) u_dec (
        .wr      (cpu_wr),
        .addr_hi (cpu_addr[15:12]),
        .tgt     (tgt)
    );

    cbc_bank_regs #(
        .FLAVOR    (FLAVOR),
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS),
        .ROM_BW    (ROM_BW),
        .RAM_BW    (RAM_BW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_on   (ram_on)
    );

    cbc_addr_map #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW)) u_map (
        .addr       (cpu_addr),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank),
        .ram_on     (ram_on),
        .rom_addr   (rom_addr),
        .ram_addr   (ram_addr),
        .ram_access (ram_access)
    );

endmodule

// File: rtl/cbc_chk.sv
// Property checker for cart_bank_ctrl, attached by bind.
// Assumes: connected to the top's bus ports and its internal bank state.
module cbc_chk #(
    parameter int unsigned FLAVOR    = 2,
    parameter int unsigned ROM_BANKS = 512,
    parameter int unsigned ROM_BW    = 9,
    parameter int unsigned RAM_BW    = 4,
    parameter int unsigned ROM_AW    = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_access,
    input logic [ROM_BW-1:0] rom_bank,
    input logic [RAM_BW-1:0] ram_bank,
    input logic              ram_on
);

    logic lo_cmd;
    logic lo_zero;

    // Purpose: recognise a low ROM field write carrying a zero value
    always_comb begin
        if (FLAVOR == 2) begin
            lo_cmd  = cpu_wr && (cpu_addr[15:12] == 4'h2);
            lo_zero = (cpu_wdata == 8'h00);
        end else if (FLAVOR == 1) begin
            lo_cmd  = cpu_wr && (cpu_addr[15:13] == 3'd1);
            lo_zero = (cpu_wdata[6:0] == 7'd0);
        end else begin
            lo_cmd  = cpu_wr && (cpu_addr[15:13] == 3'd1);
            lo_zero = (cpu_wdata[4:0] == 5'd0);
        end
    end

    // R11
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr || cpu_addr[15]) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_on)));

    // R2
    ram_enable_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'd0) |=> (ram_on == ($past(cpu_wdata[3:0]) == 4'hA)));

    // R2
    ram_access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_on || cpu_addr[15:13] != 3'b101) |-> !ram_access);

    // R3
    fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:14] == '0));

    // R3
    switch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1:14] == rom_bank));

    generate
        if (ROM_BANKS > 1) begin : g_zero
            // R5 R8 R9
            zero_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (lo_cmd && lo_zero) |=> rom_bank[0]);
        end
    endgenerate

endmodule

bind cart_bank_ctrl cbc_chk #(
    .FLAVOR    (FLAVOR),
    .ROM_BANKS (ROM_BANKS),
    .ROM_BW    (ROM_BW),
    .RAM_BW    (RAM_BW),
    .ROM_AW    (ROM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .rom_addr   (rom_addr),
    .ram_access (ram_access),
    .rom_bank   (rom_bank),
    .ram_bank   (ram_bank),
    .ram_on     (ram_on)
);

// File: tb/cart_bank_ctrl_tb_top.sv
// Bench: three controllers, one per command set, sharing the bus.
// sel 0: set 0, 128 ROM / 4 RAM banks; sel 1: set 1, 64 / 4;
// sel 2 (dut_i): set 2, 512 / 16.
module cart_bank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [2:0]  wr;

    logic [20:0] ra0;  logic [14:0] xa0;  logic acc0;
    logic [19:0] ra1;  logic [14:0] xa1;  logic acc1;
    logic [22:0] ra2;  logic [16:0] xa2;  logic acc2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cart_bank_ctrl #(.FLAVOR(0), .ROM_BANKS(128), .RAM_BANKS(4)) dut52_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_wr(wr[0]),
        .rom_addr(ra0), .ram_addr(xa0), .ram_access(acc0));

    cart_bank_ctrl #(.FLAVOR(1), .ROM_BANKS(64), .RAM_BANKS(4)) dut7_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_wr(wr[1]),
        .rom_addr(ra1), .ram_addr(xa1), .ram_access(acc1));

    cart_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_wr(wr[2]),
        .rom_addr(ra2), .ram_addr(xa2), .ram_access(acc2));

    // {sel, req, cmd addr, cmd data, probe addr, exp rom bank, exp ram bank, exp enable}
    localparam int NV = 26;
    localparam logic [63:0] VEC [NV] = '{
        {2'd0, 8'd2,  16'h0000, 8'h0A, 16'hA123, 9'h001, 4'h0, 1'b1}, // R2 enable
        {2'd0, 8'd5,  16'h2000, 8'h13, 16'h4005, 9'h013, 4'h0, 1'b1}, // R5 low field
        {2'd0, 8'd6,  16'h4000, 8'h02, 16'h7FFF, 9'h053, 4'h0, 1'b1}, // R6 mode 0 -> rom 6:5
        {2'd0, 8'd5,  16'h2000, 8'hE0, 16'h4000, 9'h041, 4'h0, 1'b1}, // R5 zero -> 1
        {2'd0, 8'd7,  16'h6000, 8'h01, 16'h4000, 9'h041, 4'h0, 1'b1}, // R7 mode set
        {2'd0, 8'd6,  16'h4000, 8'h03, 16'hB456, 9'h041, 4'h3, 1'b1}, // R6 mode 1 -> ram
        {2'd0, 8'd7,  16'h6000, 8'hFE, 16'h4000, 9'h041, 4'h3, 1'b1}, // R7 mode clear
        {2'd0, 8'd6,  16'h5FFF, 8'h01, 16'hA000, 9'h021, 4'h3, 1'b1}, // R6 rom 6:5 again
        {2'd0, 8'd11, 16'h8000, 8'h00, 16'h4000, 9'h021, 4'h3, 1'b1}, // R11 high write
        {2'd0, 8'd2,  16'h1FFF, 8'h0B, 16'hA000, 9'h021, 4'h3, 1'b0}, // R2 disable
        {2'd0, 8'd2,  16'h0000, 8'hFA, 16'hBFFF, 9'h021, 4'h3, 1'b1}, // R2 low nibble only
        {2'd0, 8'd3,  16'hC000, 8'h55, 16'h3FFF, 9'h021, 4'h3, 1'b1}, // R3 fixed window
        {2'd1, 8'd8,  16'h2000, 8'h05, 16'h4000, 9'h005, 4'h0, 1'b0}, // R8 rom bank
        {2'd1, 8'd8,  16'h3FFF, 8'h80, 16'h6000, 9'h001, 4'h0, 1'b0}, // R8 zero -> 1
        {2'd1, 8'd10, 16'h2000, 8'h7F, 16'h4ABC, 9'h03F, 4'h0, 1'b0}, // R10 mask 63
        {2'd1, 8'd10, 16'h2000, 8'h40, 16'h4000, 9'h000, 4'h0, 1'b0}, // R10 mask after remap
        {2'd1, 8'd8,  16'h4000, 8'hFE, 16'hA000, 9'h000, 4'h2, 1'b0}, // R8 ram bank
        {2'd1, 8'd8,  16'h6000, 8'h01, 16'h7000, 9'h000, 4'h2, 1'b0}, // R8 no effect
        {2'd2, 8'd9,  16'h2000, 8'hFF, 16'h4000, 9'h0FF, 4'h0, 1'b0}, // R9 low byte
        {2'd2, 8'd9,  16'h3000, 8'h01, 16'h4000, 9'h1FF, 4'h0, 1'b0}, // R9 bit 8 set
        {2'd2, 8'd9,  16'h2FFF, 8'h00, 16'h4000, 9'h101, 4'h0, 1'b0}, // R9 zero -> 1
        {2'd2, 8'd9,  16'h3FFF, 8'hFE, 16'h4000, 9'h001, 4'h0, 1'b0}, // R9 bit 8 clear
        {2'd2, 8'd9,  16'h4000, 8'h3C, 16'hA000, 9'h001, 4'hC, 1'b0}, // R9 ram 4 bits
        {2'd2, 8'd4,  16'h5000, 8'h07, 16'hA001, 9'h001, 4'h7, 1'b0}, // R4 ram address
        {2'd2, 8'd2,  16'h1000, 8'h0A, 16'hBFFF, 9'h001, 4'h7, 1'b1}, // R2 enable set 2
        {2'd2, 8'd9,  16'h7000, 8'h33, 16'h4000, 9'h001, 4'h7, 1'b1}  // R9 no effect
    };

    // Compare outputs of one controller against values derived from R3/R4/R2
    task automatic probe_chk(input int sel, input logic [15:0] p, input logic [8:0] erom,
                             input logic [3:0] eram, input logic een, input int req);
        logic [22:0] arom, xrom;
        logic [16:0] aram, xram;
        logic        aacc, xacc;
        addr = p;
        wr   = 3'b000;
        #1;
        case (sel)
            0:       begin arom = 23'(ra0); aram = 17'(xa0); aacc = acc0; end
            1:       begin arom = 23'(ra1); aram = 17'(xa1); aacc = acc1; end
            default: begin arom = 23'(ra2); aram = 17'(xa2); aacc = acc2; end
        endcase
        xrom = p[14] ? 23'({erom, p[13:0]}) : 23'(p[13:0]);
        xram = 17'({eram, p[12:0]});
        xacc = een && (p[15:13] == 3'b101);
        if (p[15]) arom = xrom;
        n_chk++;
        if (arom != xrom || aram != xram || aacc != xacc) begin
            n_fail++;
            $display("FAIL R%0d sel%0d probe %h: rom %h/%h ram %h/%h acc %b/%b (actual/expected)",
                     req, sel, p, arom, xrom, aram, xram, aacc, xacc);
        end
    endtask

    task automatic do_cmd(input int sel, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr = 3'b000;
        wr[sel] = 1'b1;
        @(negedge clk);
        wr = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        addr  = 16'h0000;
        wdata = 8'h00;
        wr    = 3'b000;
        repeat (3) @(negedge clk);
        // R1 while reset is held
        probe_chk(2, 16'h4000, 9'h001, 4'h0, 1'b0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of every controller
        for (int s = 0; s < 3; s++) probe_chk(s, 16'h4000, 9'h001, 4'h0, 1'b0, 1);
        probe_chk(0, 16'hA000, 9'h001, 4'h0, 1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            do_cmd(int'(VEC[i][63:62]), VEC[i][53:38], VEC[i][37:30]);
            probe_chk(int'(VEC[i][63:62]), VEC[i][29:14], VEC[i][13:5],
                      VEC[i][4:1], VEC[i][0], int'(VEC[i][61:54]));
        end

        // R11 command-looking bus activity without the strobe
        @(negedge clk);
        addr = 16'h2000; wdata = 8'h09; wr = 3'b000;
        @(negedge clk);
        addr = 16'h0000; wdata = 8'h00;
        @(negedge clk);
        probe_chk(2, 16'h4000, 9'h001, 4'h7, 1'b1, 11);
        probe_chk(0, 16'h4000, 9'h021, 4'h3, 1'b1, 11);

        // R1 reset applied mid-run restores the initial state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        probe_chk(2, 16'hA000, 9'h001, 4'h0, 1'b0, 1);
        probe_chk(0, 16'h4000, 9'h001, 4'h0, 1'b0, 1);
        probe_chk(1, 16'h4000, 9'h001, 4'h0, 1'b0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule